// File: doc/BRIEF.md
# Timer-Paced VGA Line Scan-Out Engine

This block produces the horizontal and vertical sync for a raster display and streams each visible line's pixels onto a parallel pixel port. A free-running line counter sets the line period and the point at which horizontal sync asserts. That compare point also serves as the per-line event that advances the line index, and the line index drives vertical sync. Each time the line counter returns to zero on a visible line, a one-cycle arming step starts the line's transfer.

Once the transfer is armed, a separate transfer-rate counter paces the fetches. Each wrap of that counter requests one cell (a fixed group of pixels) from an external line buffer through a synchronous read port. The cell is shifted onto the pixel port one pixel per clock, lowest lane first. When every cell of the line has been requested and shifted out, a reset stage forces the black value. In dual-channel mode the cells are split between two channels that take turns on successive transfer ticks, and the reset stage waits for both channels to finish.

All run-time settings are sampled while reset is asserted and are held until the next reset. Sync polarity and the black value are elaboration parameters.

Top module: `vga_scan_engine`

## Requirements
- R1: The line counter counts 0, 1, ..., cfg_line_limit and then returns to 0, so the line period is cfg_line_limit+1 clocks. The first cycle after reset release has counter value 0.
- R2: Horizontal sync is active in every cycle whose line counter value is greater than cfg_hsync_at and at most cfg_line_limit, and inactive otherwise. With the default HS_ACT_LOW=1, active means hsync=0. During reset hsync is inactive.
- R3: When the line counter is 0 on a visible line, the arming cycle that follows issues no read. The first read request (rd_en=1) appears cfg_xfer_limit+3 cycles after the counter-zero cycle, and later requests follow every cfg_xfer_limit+1 cycles. A line makes exactly cfg_cells requests, and rd_addr equals the cell index 0, 1, 2, ....
- R4: rd_data is expected one cycle after rd_en. Pixel j of a cell occupies rd_data bits [j*PIX_W +: PIX_W]. That pixel appears on pix 3+j cycles after the cycle in which the request was high.
- R5: In every cycle where no fetched pixel is being presented, including after the last pixel of a line and during reset, pix equals BLACK (default 0).
- R6: The line index starts at 0, advances in the cycle after the line counter equals cfg_hsync_at, and returns to 0 after cfg_lines-1. Vertical sync is active (low by default) while the index lies in [cfg_vs_start, cfg_vs_end], and it changes only in that same cycle.
- R7: On a line whose index is cfg_vis_lines or more, a counter-zero event issues no read request and pix stays BLACK for the whole line.
- R8: With cfg_dual=1, the cells of a line are requested by channel 0 and channel 1 in turn, starting with channel 0, so cell c is reported with rd_chan = c mod 2. With cfg_dual=0, every request has rd_chan=0.
- R9: cfg_err goes high, and stays high until reset, when a cell's data arrives while the previous cell still has more than one pixel left to shift. This happens when cfg_xfer_limit+1 < CELL_PIX. cfg_err stays 0 when cfg_xfer_limit+1 equals CELL_PIX, and the pixels then follow each other without a gap.
- R10: Changes to the cfg_* inputs after reset release have no effect on sync, reads or pixels until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset; settings are sampled while low |
| cfg_line_limit | input | LT_W | Last line-counter value before wrap |
| cfg_hsync_at | input | LT_W | Line-counter compare value for hsync and the line event |
| cfg_xfer_limit | input | XT_W | Last transfer-counter value before wrap |
| cfg_cells | input | CA_W+1 | Cells per line |
| cfg_dual | input | 1 | 1 = split cells between two alternating channels |
| cfg_lines | input | LN_W | Lines per frame |
| cfg_vis_lines | input | LN_W | Number of visible lines at the top of the frame |
| cfg_vs_start | input | LN_W | First line index with vertical sync active |
| cfg_vs_end | input | LN_W | Last line index with vertical sync active |
| rd_en | output | 1 | Line-buffer read request |
| rd_addr | output | CA_W | Cell index being requested |
| rd_chan | output | 1 | Channel that issued the request |
| rd_data | input | CELL_PIX*PIX_W | Cell data, valid one cycle after rd_en |
| pix | output | PIX_W | Pixel output |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| cfg_err | output | 1 | Sticky flag: a cell was overrun before it finished shifting |

## Verification
Several properties are checked on every cycle: the line-counter wrap, the hsync set point, and vertical sync changing only right after the hsync compare. Also checked each cycle: a read follows only a running-state cycle, a blanked line never leaves idle, dual-mode requests alternate channels, single mode uses only channel 0, and the error flag stays set once raised. Only the bench's scenarios can show the exact cycle of the first request after line start, the pixel-by-pixel placement and lane order of each cell, and the black that follows the last pixel. The same holds for the seamless case at the cell-length boundary, the overrun that raises the error, odd cell counts split across two channels, and the settings being ignored after reset.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;

    // Transfer sequencer states
    typedef enum logic [2:0] {
        SQ_IDLE,   // waiting for a visible line start
        SQ_INIT,   // arming step, no pixels
        SQ_RUN,    // cells released on transfer-counter wraps
        SQ_FLUSH,  // all cells requested, waiting for shifter to drain
        SQ_BLACK   // reset stage forcing the black value
    } seq_state_t;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/vga_line_timing.sv
module vga_line_timing #(
    parameter int LT_W = 11,
    parameter int LN_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LT_W-1:0] lim,
    input  logic [LT_W-1:0] hs_at,
    input  logic [LN_W-1:0] lines,
    input  logic [LN_W-1:0] vis_lines,
    input  logic [LN_W-1:0] vs_start,
    input  logic [LN_W-1:0] vs_end,
    output logic            line_start,
    output logic            line_visible,
    output logic            hs_act,
    output logic            vs_act
);

    typedef struct packed {
        logic [LT_W-1:0] lt;
        logic            hs;
        logic [LN_W-1:0] ln;
        logic            vs;
    } tm_t;

    tm_t tm_d, tm_q;
    logic hit_hs, hit_lim;

    always_comb begin
        tm_d    = tm_q;
        hit_hs  = (tm_q.lt == hs_at);
        hit_lim = (tm_q.lt == lim);
        tm_d.lt = hit_lim ? '0 : tm_q.lt + LT_W'(1);
        if (hit_hs) begin
            tm_d.hs = 1'b1;
        end else if (hit_lim) begin
            tm_d.hs = 1'b0;
        end
        if (hit_hs) begin
            tm_d.ln = (tm_q.ln == lines - LN_W'(1)) ? '0 : tm_q.ln + LN_W'(1);
        end
        tm_d.vs = (tm_d.ln >= vs_start) && (tm_d.ln <= vs_end);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign line_start   = (tm_q.lt == '0);
    assign line_visible = (tm_q.ln < vis_lines);
    assign hs_act       = tm_q.hs;
    assign vs_act       = tm_q.vs;

    AST_LT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_q.lt == lim) |=> (tm_q.lt == '0)); // R1
    AST_HS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_q.lt == hs_at) |=> tm_q.hs); // R2
    AST_VS_ON_LINE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tm_q.vs) |-> $past(tm_q.lt == hs_at)); // R6

endmodule

// File: rtl/vga_xfer_seq.sv
module vga_xfer_seq
    import vga_scan_pkg::*;
#(
    parameter int XT_W = 8,
    parameter int CA_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XT_W-1:0] xfer_lim,
    input  logic [CA_W:0]   cells,
    input  logic            dual,
    input  logic            line_start,
    input  logic            line_visible,
    input  logic            cell_busy,
    output logic            rd_en,
    output logic [CA_W-1:0] rd_addr,
    output logic            rd_chan,
    output logic            force_black
);

    typedef struct packed {
        seq_state_t                   st;
        logic [XT_W-1:0]              xt;
        logic [NUM_CH-1:0][CA_W:0]    rem;
        logic [NUM_CH-1:0][CA_W-1:0]  nxt;
        logic                         turn;
        logic                         rd_en;
        logic [CA_W-1:0]              addr;
        logic                         chan;
        logic                         last_chan;
    } sq_t;

    sq_t sq_d, sq_q;
    logic            tick;
    logic            ch;
    logic [CA_W-1:0] step;
    logic [CA_W:0]   left;
    logic [CA_W:0]   half_up;

    always_comb begin
        sq_d       = sq_q;
        sq_d.rd_en = 1'b0;
        tick       = (sq_q.xt == xfer_lim);
        sq_d.xt    = tick ? '0 : sq_q.xt + XT_W'(1);
        ch         = sq_q.turn;
        step       = dual ? CA_W'(2) : CA_W'(1);
        left       = sq_q.rem[0] + sq_q.rem[1];
        half_up    = (CA_W+1)'(({1'b0, cells} + 1'b1) >> 1);
        unique case (sq_q.st)
            SQ_IDLE: begin
                if (line_start && line_visible) begin
                    sq_d.st = SQ_INIT;
                end
            end
            SQ_INIT: begin
                sq_d.xt     = '0;
                sq_d.rem[0] = dual ? half_up : cells;
                sq_d.rem[1] = dual ? (cells >> 1) : '0;
                sq_d.nxt[0] = '0;
                sq_d.nxt[1] = CA_W'(1);
                sq_d.turn   = 1'b0;
                sq_d.chan   = 1'b1;
                sq_d.st     = (cells == '0) ? SQ_FLUSH : SQ_RUN;
            end
            SQ_RUN: begin
                if (tick) begin
                    sq_d.rd_en     = 1'b1;
                    sq_d.addr      = sq_q.nxt[ch];
                    sq_d.chan      = ch;
                    sq_d.last_chan = sq_q.chan;
                    sq_d.rem[ch]   = sq_q.rem[ch] - (CA_W+1)'(1);
                    sq_d.nxt[ch]   = sq_q.nxt[ch] + step;
                    sq_d.turn      = dual & ~sq_q.turn;
                    if (left == (CA_W+1)'(1)) begin
                        sq_d.st = SQ_FLUSH;
                    end
                end
            end
            SQ_FLUSH: begin
                if (!sq_q.rd_en && !cell_busy) begin
                    sq_d.st = SQ_BLACK;
                end
            end
            SQ_BLACK: begin
                sq_d.st = SQ_IDLE;
            end
            default: sq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q    <= '0;
            sq_q.st <= SQ_IDLE;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign rd_en       = sq_q.rd_en;
    assign rd_addr     = sq_q.addr;
    assign rd_chan     = sq_q.chan;
    assign force_black = (sq_q.st == SQ_BLACK);

    AST_RD_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.rd_en |-> $past(sq_q.st == SQ_RUN)); // R3
    AST_BLANK_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.st == SQ_IDLE && line_start && !line_visible) |=> (sq_q.st == SQ_IDLE)); // R7
    AST_CHAN_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.rd_en && dual) |-> (sq_q.chan != sq_q.last_chan)); // R8
    AST_SINGLE_CHAN0: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.rd_en && !dual) |-> !sq_q.chan); // R8

endmodule

// File: rtl/vga_cell_shifter.sv
module vga_cell_shifter #(
    parameter int               PIX_W    = 8,
    parameter int               CELL_PIX = 4,
    parameter logic [PIX_W-1:0] BLACK    = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  logic [PIX_W*CELL_PIX-1:0] rd_data,
    input  logic                      force_black,
    output logic [PIX_W-1:0]          pix,
    output logic                      cell_busy,
    output logic                      err
);

    localparam int WW = PIX_W * CELL_PIX;
    localparam int CW = $clog2(CELL_PIX + 1);

    typedef struct packed {
        logic             ld;
        logic [WW-1:0]    sh;
        logic [CW-1:0]    cnt;
        logic [PIX_W-1:0] pix;
        logic             err;
    } shf_t;

    shf_t shf_d, shf_q;
    logic [WW-1:0] sh_next;

    // Lane i takes lane i+1; the top lane fills with black
    for (genvar i = 0; i < CELL_PIX; i++) begin : g_lane
        if (i == CELL_PIX - 1) begin : g_top
            assign sh_next[i*PIX_W +: PIX_W] = BLACK;
        end else begin : g_mid
            assign sh_next[i*PIX_W +: PIX_W] = shf_q.sh[(i+1)*PIX_W +: PIX_W];
        end
    end

    always_comb begin
        shf_d    = shf_q;
        shf_d.ld = rd_en;
        if (shf_q.ld) begin
            if (shf_q.cnt > CW'(1)) begin
                shf_d.err = 1'b1;
            end
            shf_d.sh  = rd_data;
            shf_d.cnt = CW'(CELL_PIX);
        end else if (shf_q.cnt != '0) begin
            shf_d.sh  = sh_next;
            shf_d.cnt = shf_q.cnt - CW'(1);
        end
        shf_d.pix = ((shf_q.cnt != '0) && !force_black) ? shf_q.sh[PIX_W-1:0] : BLACK;
        if (force_black) begin
            shf_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q     <= '0;
            shf_q.pix <= BLACK;
        end else begin
            shf_q <= shf_d;
        end
    end

    assign pix       = shf_q.pix;
    assign cell_busy = shf_q.ld || (shf_q.cnt != '0);
    assign err       = shf_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        shf_q.err |=> shf_q.err); // R9
    AST_FORCE_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        force_black |=> (pix == BLACK)); // R5

endmodule

// File: rtl/vga_scan_engine.sv
module vga_scan_engine #(
    parameter int               PIX_W      = 8,
    parameter int               CELL_PIX   = 4,
    parameter int               CA_W       = 6,
    parameter int               LT_W       = 11,
    parameter int               XT_W       = 8,
    parameter int               LN_W       = 10,
    parameter logic [PIX_W-1:0] BLACK      = '0,
    parameter bit               HS_ACT_LOW = 1'b1,
    parameter bit               VS_ACT_LOW = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LT_W-1:0]           cfg_line_limit,
    input  logic [LT_W-1:0]           cfg_hsync_at,
    input  logic [XT_W-1:0]           cfg_xfer_limit,
    input  logic [CA_W:0]             cfg_cells,
    input  logic                      cfg_dual,
    input  logic [LN_W-1:0]           cfg_lines,
    input  logic [LN_W-1:0]           cfg_vis_lines,
    input  logic [LN_W-1:0]           cfg_vs_start,
    input  logic [LN_W-1:0]           cfg_vs_end,
    output logic                      rd_en,
    output logic [CA_W-1:0]           rd_addr,
    output logic                      rd_chan,
    input  logic [PIX_W*CELL_PIX-1:0] rd_data,
    output logic [PIX_W-1:0]          pix,
    output logic                      hsync,
    output logic                      vsync,
    output logic                      cfg_err
);

    typedef struct packed {
        logic [LT_W-1:0] line_limit;
        logic [LT_W-1:0] hsync_at;
        logic [XT_W-1:0] xfer_limit;
        logic [CA_W:0]   cells;
        logic            dual;
        logic [LN_W-1:0] lines;
        logic [LN_W-1:0] vis_lines;
        logic [LN_W-1:0] vs_start;
        logic [LN_W-1:0] vs_end;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // Settings follow the inputs only while reset is held
    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            cfg_d.line_limit = cfg_line_limit;
            cfg_d.hsync_at   = cfg_hsync_at;
            cfg_d.xfer_limit = cfg_xfer_limit;
            cfg_d.cells      = cfg_cells;
            cfg_d.dual       = cfg_dual;
            cfg_d.lines      = cfg_lines;
            cfg_d.vis_lines  = cfg_vis_lines;
            cfg_d.vs_start   = cfg_vs_start;
            cfg_d.vs_end     = cfg_vs_end;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    logic line_start, line_visible, hs_act, vs_act;
    logic cell_busy, force_black;

    vga_line_timing #(
        .LT_W (LT_W),
        .LN_W (LN_W)
    ) i_timing (
        .clk          (clk),
        .rst_n        (rst_n),
        .lim          (cfg_q.line_limit),
        .hs_at        (cfg_q.hsync_at),
        .lines        (cfg_q.lines),
        .vis_lines    (cfg_q.vis_lines),
        .vs_start     (cfg_q.vs_start),
        .vs_end       (cfg_q.vs_end),
        .line_start   (line_start),
        .line_visible (line_visible),
        .hs_act       (hs_act),
        .vs_act       (vs_act)
    );

    vga_xfer_seq #(
        .XT_W (XT_W),
        .CA_W (CA_W)
    ) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer_lim     (cfg_q.xfer_limit),
        .cells        (cfg_q.cells),
        .dual         (cfg_q.dual),
        .line_start   (line_start),
        .line_visible (line_visible),
        .cell_busy    (cell_busy),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .rd_chan      (rd_chan),
        .force_black  (force_black)
    );

    vga_cell_shifter #(
        .PIX_W    (PIX_W),
        .CELL_PIX (CELL_PIX),
        .BLACK    (BLACK)
    ) i_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .rd_data     (rd_data),
        .force_black (force_black),
        .pix         (pix),
        .cell_busy   (cell_busy),
        .err         (cfg_err)
    );

    assign hsync = hs_act ^ HS_ACT_LOW;
    assign vsync = vs_act ^ VS_ACT_LOW;

endmodule

// File: tb/test_vga_scan_engine.sv
module test_vga_scan_engine;

    localparam int PIX_W    = 8;
    localparam int CELL_PIX = 4;
    localparam int CA_W     = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                      rst_n;
    logic [10:0]               cfg_line_limit, cfg_hsync_at;
    logic [7:0]                cfg_xfer_limit;
    logic [CA_W:0]             cfg_cells;
    logic                      cfg_dual;
    logic [9:0]                cfg_lines, cfg_vis_lines, cfg_vs_start, cfg_vs_end;
    logic                      rd_en, rd_chan, hsync, vsync, cfg_err;
    logic [CA_W-1:0]           rd_addr;
    logic [PIX_W*CELL_PIX-1:0] rd_data;
    logic [PIX_W-1:0]          pix;

    vga_scan_engine i_vga_scan_engine (
        .clk(clk), .rst_n(rst_n),
        .cfg_line_limit(cfg_line_limit), .cfg_hsync_at(cfg_hsync_at),
        .cfg_xfer_limit(cfg_xfer_limit), .cfg_cells(cfg_cells), .cfg_dual(cfg_dual),
        .cfg_lines(cfg_lines), .cfg_vis_lines(cfg_vis_lines),
        .cfg_vs_start(cfg_vs_start), .cfg_vs_end(cfg_vs_end),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_chan(rd_chan), .rd_data(rd_data),
        .pix(pix), .hsync(hsync), .vsync(vsync), .cfg_err(cfg_err)
    );

    // Pixel j of cell a carries the value a*16 + j + 1 (never black)
    function automatic logic [PIX_W-1:0] pix_val(int a, int j);
        return PIX_W'(a * 16 + j + 1);
    endfunction

    function automatic logic [PIX_W*CELL_PIX-1:0] cell_word(int a);
        logic [PIX_W*CELL_PIX-1:0] w;
        for (int j = 0; j < CELL_PIX; j++) w[j*PIX_W +: PIX_W] = pix_val(a, j);
        return w;
    endfunction

    // Synchronous line buffer model: data one cycle after the request
    always @(posedge clk) if (rd_en) rd_data <= cell_word(int'(rd_addr));

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(string req, int n, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d actual=%0h expected=%0h", req, n, act, exp);
        end
    endtask

    typedef struct packed {
        int l; int h; int x; int c; int nl; int vis;
        int vs0; int vs1; int dual; int chkpix; int cyc;
    } vec_t;

    // line limit, hsync point, xfer limit, cells, lines, visible, vs start, vs end, dual, pixel check, cycles
    localparam vec_t VECS [5] = '{
        '{99,  79, 7, 6, 5, 3, 3, 3, 0, 1, 1100},
        '{99,  85, 3, 8, 4, 2, 2, 3, 0, 1,  900},
        '{119, 100, 9, 5, 5, 4, 4, 4, 1, 1, 1300},
        '{89,  60, 4, 6, 6, 3, 4, 5, 1, 1, 1200},
        '{99,  79, 1, 8, 4, 2, 2, 2, 0, 0,  500}
    };

    task automatic run_vec(vec_t v, bit first);
        int p;
        rst_n          = 1'b0;
        cfg_line_limit = 11'(v.l);
        cfg_hsync_at   = 11'(v.h);
        cfg_xfer_limit = 8'(v.x);
        cfg_cells      = 7'(v.c);
        cfg_dual       = v.dual[0];
        cfg_lines      = 10'(v.nl);
        cfg_vis_lines  = 10'(v.vis);
        cfg_vs_start   = 10'(v.vs0);
        cfg_vs_end     = 10'(v.vs1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (first) begin
            chk("R5 reset pix", -1, 32'(pix), 32'h0);
            chk("R2 reset hsync", -1, 32'(hsync), 32'h1);
            chk("R6 reset vsync", -1, 32'(vsync), 32'h1);
            chk("R3 reset rd_en", -1, 32'(rd_en), 32'h0);
            chk("R9 reset err", -1, 32'(cfg_err), 32'h0);
        end
        rst_n = 1'b1;
        p = v.l + 1;
        for (int n = 0; n < v.cyc; n++) begin
            int k, d, ln, d0, d1, c, j;
            bit vis, hs_a, vs_a, exp_rd;
            logic [PIX_W-1:0] exp_pix;
            k    = n / p;
            d    = n % p;
            hs_a = (d > v.h);
            ln   = (n > v.h) ? (((n - v.h - 1) / p + 1) % v.nl) : 0;
            vs_a = (ln >= v.vs0) && (ln <= v.vs1);
            vis  = ((k % v.nl) < v.vis);
            exp_pix = '0;
            d0 = d - (6 + v.x);
            if (vis && d0 >= 0) begin
                c = d0 / (v.x + 1);
                j = d0 % (v.x + 1);
                if (c < v.c && j < CELL_PIX) exp_pix = pix_val(c, j);
            end
            exp_rd = 1'b0;
            d1 = d - (3 + v.x);
            c  = (d1 >= 0) ? d1 / (v.x + 1) : 0;
            if (vis && d1 >= 0 && (d1 % (v.x + 1)) == 0 && c < v.c) exp_rd = 1'b1;

            chk("R1/R2/R10 hsync", n, 32'(hsync), 32'(!hs_a));
            chk("R6 vsync", n, 32'(vsync), 32'(!vs_a));
            if (v.chkpix != 0) begin
                if (!vis)
                    chk("R7 blank pix", n, 32'(pix), 32'h0);
                else if (exp_pix == '0)
                    chk("R5 black pix", n, 32'(pix), 32'h0);
                else
                    chk("R4 pixel", n, 32'(pix), 32'(exp_pix));
                chk(vis ? "R3 rd_en" : "R7 rd_en", n, 32'(rd_en), 32'(exp_rd));
                if (exp_rd) begin
                    chk("R3 rd_addr", n, 32'(rd_addr), 32'(c));
                    chk("R8 rd_chan", n, 32'(rd_chan), (v.dual != 0) ? 32'(c % 2) : 32'h0);
                end
            end
            if (n == 0) begin
                chk("R9 err at start", n, 32'(cfg_err), 32'h0);
                // R10: disturb every setting once reset is released
                cfg_line_limit = 11'd17;
                cfg_hsync_at   = 11'd3;
                cfg_xfer_limit = 8'd0;
                cfg_cells      = 7'd1;
                cfg_dual       = ~cfg_dual;
                cfg_lines      = 10'd2;
                cfg_vis_lines  = 10'd0;
                cfg_vs_start   = 10'd0;
                cfg_vs_end     = 10'd1;
            end
            @(negedge clk);
        end
        chk("R9 err at end", v.cyc, 32'(cfg_err), (v.chkpix != 0) ? 32'h0 : 32'h1);
    endtask

    initial begin
        rst_n   = 1'b0;
        rd_data = '0;
        for (int i = 0; i < 5; i++) run_vec(VECS[i], i == 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired, actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule